// File: doc/BRIEF.md
# Floppy Controller Command and Result Sequencer

This block is the part of a floppy disk controller that the host CPU talks to. It has a four-register window: main status, data port, interrupt status and a digital output register. The host writes a command as a sequence of bytes into the data port. The block then spends one cycle on a placeholder execution step, which fills a result buffer from the controller's position state. After that the host reads the result bytes back through the same port.

The number of bytes each command takes, and how many result bytes it returns, comes from a lookup on the low five bits of the first byte. The digital output register drives the drive-select lines, the motor enables and the DMA/interrupt enable. It also carries an active-low reset bit. Clearing that bit arms a soft reset; setting it again aborts any command in flight.

The sequencer has four states:
- IDLE: waiting for a first byte.
- CMD: collecting the remaining bytes.
- EXEC: a single cycle.
- RESULT: returning bytes.

Its transitions:
- IDLE→CMD on a first byte when the command is longer than one byte.
- IDLE→EXEC or CMD→EXEC on the last command byte.
- EXEC→RESULT when the result count is nonzero, EXEC→IDLE when it is zero.
- RESULT→IDLE on the read of the last result byte.
- Any state→IDLE on soft reset.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset the main status reads 0x80 and the interrupt status reads 0x00. Drive select, motor enables and DMA enable are all 0.
- R2: The opcode is bits 4:0 of the first command byte, and the upper bits are ignored. Command byte counts by opcode are:
  - 0x05 and 0x06: 9 bytes.
  - 0x0D: 6 bytes.
  - 0x03 and 0x0F: 3 bytes.
  - 0x04, 0x07 and 0x0A: 2 bytes.
  - 0x08: 1 byte.
  - 0x02, 0x09, 0x0C, 0x11, 0x19 and 0x1D: 9 bytes.
  - Every other opcode: 1 byte.
- R3: The cycle after the last command byte is a single execution cycle in which the main status reads 0x00. The next cycle depends on the result count:
  - Nonzero result count: main status reads 0xC0 (bit 7 ready, bit 6 data toward host).
  - Zero result count (0x03, 0x07, 0x0F): main status reads 0x80.
- R4: Data-port reads in the result phase return the result bytes in order. After the last one the main status reads 0x80 and a new command may start.
- R5: Data-port writes during the execution or result phase have no effect. Data-port reads outside the result phase return 0x00 and change nothing.
- R6: Read (0x06), write (0x05) and format (0x0D) take cylinder, head, sector and size from bytes 2 to 5. They return 0, 0, 0, then the cylinder, head, sector and size after a one-sector advance. The advance works as follows:
  - The sector number increments.
  - Past 18 it becomes 1 and the head increments.
  - Head 2 becomes 0 and the cylinder increments.
  - Cylinder 80 becomes 0.
  - The advanced position is stored.
- R7: Seek (0x0F) stores byte 2 as the cylinder and sets bit 5 (seek end) of status 0. Recalibrate (0x07) zeroes the cylinder and sets bit 5. Sense interrupt status (0x08) returns status 0, then the stored cylinder.
- R8: Read ID (0x0A) returns 0, 0, 0, then the stored cylinder, head, sector and size.
- R9: An opcode with no defined command returns one result byte, 0x80 (invalid-command code 10 in bits 7:6), which also becomes status 0.
- R10: A write to the digital output register sets the outputs as follows:
  - Drive select from bits 1:0.
  - DMA enable from bit 3.
  - Motor enables from bits 7:4.
- R11: Writing bit 2 of the digital output register as 0 arms a soft reset and clears the interrupt. A later write with bit 2 set performs the reset. It raises the interrupt only if that write selects drive 0.
- R12: The interrupt status port reads 0xC0 while the interrupt is pending and 0x00 otherwise.
- R13: A soft reset returns the sequencer to IDLE from any phase, discards a partial command and clears status 0. The stored cylinder is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored when wr_en is high) |
| reg_sel | input | 2 | 0 main status, 1 data, 2 interrupt status, 3 digital output |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when no read is active |
| irq | output | 1 | Interrupt pending |
| drv_sel | output | 2 | Selected drive |
| motor_en | output | 4 | Motor enables |
| dma_en | output | 1 | DMA/interrupt enable |

## Verification
The assertions check four sequencer properties on every cycle:
- The execution step never lasts longer than one cycle.
- The result phase holds still without a data read.
- The final result read lands in IDLE.
- A soft reset always ends in IDLE.

They also check that the interrupt rises only with drive 0 selected, that arming clears it, and that an undefined opcode yields the invalid code.

Only the bench's scenarios can show that the byte counts match each opcode and that the result contents are right. This covers the sector, head and cylinder wrap, the state carried from one command into the next (seek into sense, read into read ID), and the abort of a half-written command.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int BYTE_W    = 8;
    localparam int OP_W      = 5;
    localparam int MAX_CMD   = 9;
    localparam int MAX_RES   = 7;
    localparam int CMD_CNT_W = $clog2(MAX_CMD + 1);
    localparam int RES_CNT_W = $clog2(MAX_RES + 1);
    localparam int SEL_W     = 2;

    // command byte positions consumed by execution
    localparam int ARG_LO       = 2;
    localparam int ARG_HI       = 5;
    localparam int ARG_CYL      = 2;
    localparam int ARG_HEAD     = 3;
    localparam int ARG_SECT     = 4;
    localparam int ARG_SIZE     = 5;
    localparam int HEADSEL_BYTE = 1;
    localparam int HEADSEL_BIT  = 2;

    // digital output register fields
    localparam int DOR_DRV_W     = 2;
    localparam int DOR_RST_BIT   = 2;
    localparam int DOR_DMA_BIT   = 3;
    localparam int DOR_MOTOR_LO  = 4;
    localparam int DOR_MOTOR_W   = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_EXEC,
        PH_RESULT
    } phase_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_MAIN = 2'd0,
        SEL_DATA = 2'd1,
        SEL_INTR = 2'd2,
        SEL_DOR  = 2'd3
    } sel_t;

    localparam logic [OP_W-1:0] OP_TRACK_RD = 5'h02;
    localparam logic [OP_W-1:0] OP_TIMING   = 5'h03;
    localparam logic [OP_W-1:0] OP_DRV_STAT = 5'h04;
    localparam logic [OP_W-1:0] OP_SECT_WR  = 5'h05;
    localparam logic [OP_W-1:0] OP_SECT_RD  = 5'h06;
    localparam logic [OP_W-1:0] OP_HOME     = 5'h07;
    localparam logic [OP_W-1:0] OP_INT_STAT = 5'h08;
    localparam logic [OP_W-1:0] OP_DEL_WR   = 5'h09;
    localparam logic [OP_W-1:0] OP_ID_RD    = 5'h0A;
    localparam logic [OP_W-1:0] OP_DEL_RD   = 5'h0C;
    localparam logic [OP_W-1:0] OP_LAYOUT   = 5'h0D;
    localparam logic [OP_W-1:0] OP_STEP_TO  = 5'h0F;
    localparam logic [OP_W-1:0] OP_CMP_EQ   = 5'h11;
    localparam logic [OP_W-1:0] OP_CMP_LE   = 5'h19;
    localparam logic [OP_W-1:0] OP_CMP_GE   = 5'h1D;

    localparam logic [BYTE_W-1:0] MAIN_READY   = 8'h80;
    localparam logic [BYTE_W-1:0] MAIN_TO_HOST = 8'h40;
    localparam logic [BYTE_W-1:0] S0_SEEK_DONE = 8'h20;
    localparam logic [BYTE_W-1:0] S0_BAD_CMD   = 8'h80;
    localparam logic [BYTE_W-1:0] INTR_ACTIVE  = 8'hC0;

endpackage

// File: rtl/fdc_len_lut.sv
module fdc_len_lut
    import fdc_pkg::*;
(
    input  logic [OP_W-1:0]      op,
    output logic [CMD_CNT_W-1:0] cmd_len,
    output logic [RES_CNT_W-1:0] res_len,
    output logic                 undefined_op
);

    always_comb begin
        undefined_op = 1'b0;
        unique case (op)
            OP_SECT_WR, OP_SECT_RD, OP_TRACK_RD, OP_DEL_WR, OP_DEL_RD,
            OP_CMP_EQ, OP_CMP_LE, OP_CMP_GE: begin
                cmd_len = CMD_CNT_W'(9);
                res_len = RES_CNT_W'(7);
            end
            OP_LAYOUT: begin
                cmd_len = CMD_CNT_W'(6);
                res_len = RES_CNT_W'(7);
            end
            OP_TIMING, OP_STEP_TO: begin
                cmd_len = CMD_CNT_W'(3);
                res_len = RES_CNT_W'(0);
            end
            OP_HOME: begin
                cmd_len = CMD_CNT_W'(2);
                res_len = RES_CNT_W'(0);
            end
            OP_DRV_STAT: begin
                cmd_len = CMD_CNT_W'(2);
                res_len = RES_CNT_W'(1);
            end
            OP_ID_RD: begin
                cmd_len = CMD_CNT_W'(2);
                res_len = RES_CNT_W'(7);
            end
            OP_INT_STAT: begin
                cmd_len = CMD_CNT_W'(1);
                res_len = RES_CNT_W'(2);
            end
            default: begin
                cmd_len      = CMD_CNT_W'(1);
                res_len      = RES_CNT_W'(1);
                undefined_op = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fdc_dor_ctl.sv
module fdc_dor_ctl
    import fdc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dor_wr,
    input  logic [BYTE_W-1:0]      wdata,
    output logic                   soft_rst,
    output logic                   irq,
    output logic [DOR_DRV_W-1:0]   drv_sel,
    output logic [DOR_MOTOR_W-1:0] motor_en,
    output logic                   dma_en
);

    logic armed_q;
    logic irq_q;
    logic [DOR_DRV_W-1:0]   drv_q;
    logic [DOR_MOTOR_W-1:0] motor_q;
    logic dma_q;

    assign soft_rst = dor_wr && wdata[DOR_RST_BIT] && armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
            drv_q   <= '0;
            motor_q <= '0;
            dma_q   <= 1'b0;
        end else if (dor_wr) begin
            drv_q   <= wdata[DOR_DRV_W-1:0];
            motor_q <= wdata[DOR_MOTOR_LO +: DOR_MOTOR_W];
            dma_q   <= wdata[DOR_DMA_BIT];
            if (wdata[DOR_RST_BIT]) begin
                if (armed_q) begin
                    armed_q <= 1'b0;
                    irq_q   <= (wdata[DOR_DRV_W-1:0] == '0);
                end
            end else if (!armed_q) begin
                armed_q <= 1'b1;
                irq_q   <= 1'b0;
            end
        end
    end

    assign irq      = irq_q;
    assign drv_sel  = drv_q;
    assign motor_en = motor_q;
    assign dma_en   = dma_q;

    assert_irq_drive0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (drv_q == '0));

    assert_arm_clears_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dor_wr && !wdata[DOR_RST_BIT]) |=> !irq_q);

endmodule

// File: rtl/fdc_exec_unit.sv
module fdc_exec_unit
    import fdc_pkg::*;
#(
    parameter int SECTORS = 18,
    parameter int HEADS   = 2,
    parameter int CYLS    = 80
)(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  soft_rst,
    input  logic                                  exec_go,
    input  logic [OP_W-1:0]                       op,
    input  logic                                  undefined_op,
    input  logic [ARG_HI:ARG_LO][BYTE_W-1:0]      args,
    input  logic                                  head_bit,
    input  logic [RES_CNT_W-1:0]                  rd_idx,
    output logic [BYTE_W-1:0]                     rd_byte
);

    localparam logic [BYTE_W-1:0] SECT_WRAP = BYTE_W'(SECTORS + 1);
    localparam logic [BYTE_W-1:0] HEAD_WRAP = BYTE_W'(HEADS);
    localparam logic [BYTE_W-1:0] CYL_WRAP  = BYTE_W'(CYLS);
    localparam logic [BYTE_W-1:0] ONE       = BYTE_W'(1);

    logic [BYTE_W-1:0] st0_q, cyl_q, head_q, sect_q, size_q;
    logic [MAX_RES-1:0][BYTE_W-1:0] res_q;
    logic [BYTE_W-1:0] nx_cyl, nx_head, nx_sect;

    // one-sector advance with track, side and disk wrap
    always_comb begin
        nx_cyl  = args[ARG_CYL];
        nx_head = args[ARG_HEAD];
        nx_sect = args[ARG_SECT] + ONE;
        if (nx_sect == SECT_WRAP) begin
            nx_sect = ONE;
            nx_head = args[ARG_HEAD] + ONE;
            if (nx_head == HEAD_WRAP) begin
                nx_head = '0;
                nx_cyl  = args[ARG_CYL] + ONE;
                if (nx_cyl == CYL_WRAP) nx_cyl = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st0_q  <= '0;
            cyl_q  <= '0;
            head_q <= '0;
            sect_q <= '0;
            size_q <= '0;
            res_q  <= '0;
        end else if (soft_rst) begin
            st0_q <= '0;
        end else if (exec_go) begin
            unique case (op)
                OP_SECT_RD, OP_SECT_WR, OP_LAYOUT: begin
                    st0_q    <= '0;
                    res_q[0] <= '0;
                    res_q[1] <= '0;
                    res_q[2] <= '0;
                    res_q[3] <= nx_cyl;
                    res_q[4] <= nx_head;
                    res_q[5] <= nx_sect;
                    res_q[6] <= args[ARG_SIZE];
                    cyl_q    <= nx_cyl;
                    head_q   <= nx_head;
                    sect_q   <= nx_sect;
                    size_q   <= args[ARG_SIZE];
                end
                OP_ID_RD: begin
                    st0_q    <= '0;
                    res_q[0] <= '0;
                    res_q[1] <= '0;
                    res_q[2] <= '0;
                    res_q[3] <= cyl_q;
                    res_q[4] <= head_q;
                    res_q[5] <= sect_q;
                    res_q[6] <= size_q;
                end
                OP_INT_STAT: begin
                    res_q[0] <= st0_q;
                    res_q[1] <= cyl_q;
                end
                OP_STEP_TO: begin
                    cyl_q  <= args[ARG_CYL];
                    head_q <= BYTE_W'(head_bit);
                    st0_q  <= S0_SEEK_DONE;
                end
                OP_HOME: begin
                    cyl_q <= '0;
                    st0_q <= st0_q | S0_SEEK_DONE;
                end
                OP_DRV_STAT: begin
                    res_q[0] <= '0;
                end
                OP_TIMING, OP_TRACK_RD, OP_DEL_WR, OP_DEL_RD,
                OP_CMP_EQ, OP_CMP_LE, OP_CMP_GE: begin
                    res_q <= res_q;
                end
                default: begin
                    st0_q    <= S0_BAD_CMD;
                    res_q[0] <= S0_BAD_CMD;
                end
            endcase
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < MAX_RES; i++) begin
            if (rd_idx == RES_CNT_W'(i)) rd_byte = res_q[i];
        end
    end

    assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && !soft_rst && undefined_op) |=> (st0_q == S0_BAD_CMD && res_q[0] == S0_BAD_CMD));

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_pkg::*;
#(
    parameter int SECTORS = 18,
    parameter int HEADS   = 2,
    parameter int CYLS    = 80
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [SEL_W-1:0]       reg_sel,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [BYTE_W-1:0]      rdata,
    output logic                   irq,
    output logic [DOR_DRV_W-1:0]   drv_sel,
    output logic [DOR_MOTOR_W-1:0] motor_en,
    output logic                   dma_en
);

    phase_t phase_q, phase_d;
    logic [CMD_CNT_W-1:0] cmd_cnt_q, cmd_cnt_inc, wr_idx;
    logic [RES_CNT_W-1:0] res_cnt_q, res_cnt_inc;
    logic [OP_W-1:0] op_q, lut_op;
    logic [ARG_HI:ARG_LO][BYTE_W-1:0] arg_q;
    logic head_bit_q;
    logic [CMD_CNT_W-1:0] lut_cmd_len;
    logic [RES_CNT_W-1:0] lut_res_len;
    logic lut_undef;
    logic soft_rst, exec_go, cmd_take;
    logic data_wr, data_rd, dor_wr;
    logic [BYTE_W-1:0] main_stat, res_byte;

    assign data_wr = wr_en && (reg_sel == SEL_DATA);
    assign data_rd = rd_en && !wr_en && (reg_sel == SEL_DATA);
    assign dor_wr  = wr_en && (reg_sel == SEL_DOR);

    assign lut_op      = (phase_q == PH_IDLE) ? wdata[OP_W-1:0] : op_q;
    assign cmd_cnt_inc = cmd_cnt_q + CMD_CNT_W'(1);
    assign res_cnt_inc = res_cnt_q + RES_CNT_W'(1);
    assign wr_idx      = (phase_q == PH_IDLE) ? '0 : cmd_cnt_q;
    assign cmd_take    = data_wr && !soft_rst &&
                         (phase_q == PH_IDLE || phase_q == PH_CMD);
    assign exec_go     = (phase_q == PH_EXEC) && !soft_rst;

    fdc_len_lut u_len_lut (
        .op           (lut_op),
        .cmd_len      (lut_cmd_len),
        .res_len      (lut_res_len),
        .undefined_op (lut_undef)
    );

    fdc_dor_ctl u_dor_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dor_wr   (dor_wr),
        .wdata    (wdata),
        .soft_rst (soft_rst),
        .irq      (irq),
        .drv_sel  (drv_sel),
        .motor_en (motor_en),
        .dma_en   (dma_en)
    );

    fdc_exec_unit #(
        .SECTORS (SECTORS),
        .HEADS   (HEADS),
        .CYLS    (CYLS)
    ) u_exec_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .exec_go      (exec_go),
        .op           (op_q),
        .undefined_op (lut_undef),
        .args         (arg_q),
        .head_bit     (head_bit_q),
        .rd_idx       (res_cnt_q),
        .rd_byte      (res_byte)
    );

    // next phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (data_wr)
                    phase_d = (lut_cmd_len == CMD_CNT_W'(1)) ? PH_EXEC : PH_CMD;
            end
            PH_CMD: begin
                if (data_wr && cmd_cnt_inc == lut_cmd_len) phase_d = PH_EXEC;
            end
            PH_EXEC: begin
                phase_d = (lut_res_len != '0) ? PH_RESULT : PH_IDLE;
            end
            PH_RESULT: begin
                if (data_rd && res_cnt_inc == lut_res_len) phase_d = PH_IDLE;
            end
        endcase
        if (soft_rst) phase_d = PH_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // byte counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_cnt_q <= '0;
            res_cnt_q <= '0;
        end else if (soft_rst) begin
            cmd_cnt_q <= '0;
            res_cnt_q <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE:   if (data_wr) cmd_cnt_q <= CMD_CNT_W'(1);
                PH_CMD:    if (data_wr) cmd_cnt_q <= cmd_cnt_inc;
                PH_EXEC: begin
                    cmd_cnt_q <= '0;
                    res_cnt_q <= '0;
                end
                PH_RESULT: begin
                    if (data_rd)
                        res_cnt_q <= (res_cnt_inc == lut_res_len) ? '0 : res_cnt_inc;
                end
            endcase
        end
    end

    // opcode and argument capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= '0;
            arg_q      <= '0;
            head_bit_q <= 1'b0;
        end else if (cmd_take) begin
            if (phase_q == PH_IDLE) op_q <= wdata[OP_W-1:0];
            if (wr_idx == CMD_CNT_W'(HEADSEL_BYTE)) head_bit_q <= wdata[HEADSEL_BIT];
            for (int i = ARG_LO; i <= ARG_HI; i++) begin
                if (wr_idx == CMD_CNT_W'(i)) arg_q[i] <= wdata;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (phase_q)
            PH_IDLE, PH_CMD: main_stat = MAIN_READY;
            PH_EXEC:         main_stat = '0;
            PH_RESULT:       main_stat = MAIN_READY | MAIN_TO_HOST;
        endcase
        rdata = '0;
        if (rd_en && !wr_en) begin
            unique case (reg_sel)
                SEL_MAIN: rdata = main_stat;
                SEL_DATA: rdata = (phase_q == PH_RESULT) ? res_byte : '0;
                SEL_INTR: rdata = irq ? INTR_ACTIVE : '0;
                SEL_DOR:  rdata = '0;
            endcase
        end
    end

    assert_exec_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXEC) |=> (phase_q != PH_EXEC));

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESULT && !data_rd && !soft_rst) |=> (phase_q == PH_RESULT && $stable(res_cnt_q)));

    assert_last_read_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESULT && data_rd && !soft_rst && res_cnt_q == lut_res_len - RES_CNT_W'(1))
        |=> (phase_q == PH_IDLE && main_stat == MAIN_READY));

    assert_abort_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (phase_q == PH_IDLE && cmd_cnt_q == '0));

endmodule

// File: tb/test_fdc_cmd_seq.sv
module test_fdc_cmd_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;
    logic [1:0] drv_sel;
    logic [3:0] motor_en;
    logic       dma_en;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    fdc_cmd_seq i_fdc_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .irq(irq),
        .drv_sel(drv_sel), .motor_en(motor_en), .dma_en(dma_en)
    );

    // ---------------- behavioural reference model ----------------
    int m_phase;          // 0 idle, 1 collecting, 2 executing, 3 returning
    int m_op;
    int m_cmd[$];
    int m_res[7];
    int m_ridx;
    int m_st0, m_cyl, m_head, m_sect, m_size;
    bit m_armed, m_irq, m_dma;
    int m_drv, m_motor;

    function automatic int need_cmd(int op);
        case (op)
            5, 6, 2, 9, 12, 17, 25, 29: return 9;
            13: return 6;
            3, 15: return 3;
            4, 7, 10: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int need_res(int op);
        case (op)
            5, 6, 2, 9, 12, 17, 25, 29, 13, 10: return 7;
            3, 15, 7: return 0;
            8: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic m_reset();
        m_phase = 0; m_op = 0; m_cmd.delete(); m_ridx = 0;
        for (int i = 0; i < 7; i++) m_res[i] = 0;
        m_st0 = 0; m_cyl = 0; m_head = 0; m_sect = 0; m_size = 0;
        m_armed = 0; m_irq = 0; m_dma = 0; m_drv = 0; m_motor = 0;
    endtask

    task automatic m_exec();
        int c, h, r;
        case (m_op)
            5, 6, 13: begin
                c = m_cmd[2]; h = m_cmd[3]; r = (m_cmd[4] + 1) & 255;
                if (r == 19) begin
                    r = 1; h = (h + 1) & 255;
                    if (h == 2) begin
                        h = 0; c = (c + 1) & 255;
                        if (c == 80) c = 0;
                    end
                end
                m_st0 = 0;
                m_res[0] = 0; m_res[1] = 0; m_res[2] = 0;
                m_res[3] = c; m_res[4] = h; m_res[5] = r; m_res[6] = m_cmd[5];
                m_cyl = c; m_head = h; m_sect = r; m_size = m_cmd[5];
            end
            10: begin
                m_st0 = 0;
                m_res[0] = 0; m_res[1] = 0; m_res[2] = 0;
                m_res[3] = m_cyl; m_res[4] = m_head; m_res[5] = m_sect; m_res[6] = m_size;
            end
            8: begin m_res[0] = m_st0; m_res[1] = m_cyl; end
            15: begin m_cyl = m_cmd[2]; m_head = (m_cmd[1] >> 2) & 1; m_st0 = 32; end
            7: begin m_cyl = 0; m_st0 = m_st0 | 32; end
            4: m_res[0] = 0;
            3, 2, 9, 12, 17, 25, 29: ;
            default: begin m_st0 = 128; m_res[0] = 128; end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            bit dw, dr, ow, sr;
            dw = wr_en && reg_sel == 2'd1;
            dr = rd_en && !wr_en && reg_sel == 2'd1;
            ow = wr_en && reg_sel == 2'd3;
            sr = ow && wdata[2] && m_armed;
            if (ow) begin
                m_drv = wdata[1:0]; m_dma = wdata[3]; m_motor = wdata[7:4];
                if (wdata[2]) begin
                    if (m_armed) begin m_armed = 0; m_irq = (wdata[1:0] == 0); end
                end else if (!m_armed) begin
                    m_armed = 1; m_irq = 0;
                end
            end
            if (sr) begin
                m_phase = 0; m_cmd.delete(); m_ridx = 0; m_st0 = 0;
            end else begin
                case (m_phase)
                    0: if (dw) begin
                        m_cmd.delete(); m_cmd.push_back(wdata); m_op = wdata[4:0];
                        m_phase = (need_cmd(m_op) == 1) ? 2 : 1;
                    end
                    1: if (dw) begin
                        m_cmd.push_back(wdata);
                        if (m_cmd.size() == need_cmd(m_op)) m_phase = 2;
                    end
                    2: begin
                        m_exec();
                        m_ridx = 0;
                        m_phase = (need_res(m_op) != 0) ? 3 : 0;
                    end
                    default: if (dr) begin
                        m_ridx++;
                        if (m_ridx == need_res(m_op)) begin m_phase = 0; m_ridx = 0; end
                    end
                endcase
            end
        end
    end

    function automatic int model_rdata();
        if (!rd_en || wr_en) return 0;
        case (reg_sel)
            2'd0: return (m_phase == 2) ? 0 : (m_phase == 3) ? 8'hC0 : 8'h80;
            2'd1: return (m_phase == 3) ? m_res[m_ridx] : 0;
            2'd2: return m_irq ? 8'hC0 : 0;
            default: return 0;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle_compare();
        chk({cur_req, " rdata"}, rdata, model_rdata());
        chk({cur_req, " irq"}, irq, m_irq);
        chk({cur_req, " R10 drive"}, drv_sel, m_drv);
        chk({cur_req, " R10 motor"}, motor_en, m_motor);
        chk({cur_req, " R10 dma"}, dma_en, m_dma);
    endtask

    task automatic step(bit w, bit r, logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; reg_sel = s; wdata = d;
        #1;
        if (rst_n) cycle_compare();
    endtask

    task automatic idle();
        step(0, 0, 2'd0, 8'h00);
    endtask

    task automatic rd_expect(logic [1:0] s, int exp, string tag);
        step(0, 1, s, 8'h00);
        chk(tag, rdata, exp);
    endtask

    task automatic send(int bytes[$]);
        foreach (bytes[i]) step(1, 0, 2'd1, bytes[i][7:0]);
    endtask

    task automatic expect_results(int vals[$], string tag);
        foreach (vals[i]) rd_expect(2'd1, vals[i], tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        cur_req = "R1";
        rd_expect(2'd0, 8'h80, "R1 main status after reset");
        rd_expect(2'd2, 8'h00, "R12 interrupt port idle");
        chk("R1 drive select after reset", drv_sel, 0);
        chk("R1 motor after reset", motor_en, 0);

        // sense interrupt status straight after reset
        cur_req = "R3";
        send('{8'h08});
        rd_expect(2'd0, 8'h00, "R3 exec cycle status");
        rd_expect(2'd0, 8'hC0, "R3 result phase status");
        expect_results('{0, 0}, "R7 sense after reset");
        rd_expect(2'd0, 8'h80, "R4 idle after last byte");

        // seek, then sense interrupt
        cur_req = "R7";
        send('{8'h0F});
        rd_expect(2'd0, 8'h80, "R2 still collecting after first byte");
        send('{8'h04, 8'h21});
        rd_expect(2'd0, 8'h00, "R3 seek exec cycle");
        rd_expect(2'd0, 8'h80, "R3 no result phase for seek");
        send('{8'h08}); idle();
        expect_results('{8'h20, 8'h21}, "R7 seek end and cylinder");

        // read data with upper opcode bits set
        cur_req = "R6";
        send('{8'h46, 0, 5, 0, 7, 2, 18, 8'h1B, 8'hFF}); idle();
        rd_expect(2'd0, 8'hC0, "R2 masked opcode gives nine-byte command");
        expect_results('{0, 0, 0, 5, 0, 8, 2}, "R6 read advance");
        rd_expect(2'd0, 8'h80, "R4 idle after seven bytes");

        cur_req = "R8";
        send('{8'h0A, 8'h00}); idle();
        expect_results('{0, 0, 0, 5, 0, 8, 2}, "R8 read id position");

        cur_req = "R6";
        send('{8'h05, 0, 79, 1, 18, 2, 18, 8'h1B, 8'hFF}); idle();
        expect_results('{0, 0, 0, 0, 0, 1, 2}, "R6 full wrap");

        send('{8'h0D, 0, 3, 0, 18, 2}); idle();
        expect_results('{0, 0, 0, 3, 1, 1, 2}, "R6 format side wrap");

        cur_req = "R7";
        send('{8'h07, 8'h00});
        rd_expect(2'd0, 8'h00, "R3 recalibrate exec cycle");
        rd_expect(2'd0, 8'h80, "R7 recalibrate no results");
        send('{8'h08}); idle();
        expect_results('{8'h20, 0}, "R7 recalibrate state");

        cur_req = "R9";
        send('{8'h1F}); idle();
        rd_expect(2'd0, 8'hC0, "R9 one result pending");
        rd_expect(2'd1, 8'h80, "R9 invalid code");
        rd_expect(2'd0, 8'h80, "R9 single byte only");

        cur_req = "R5";
        send('{8'h08}); idle();
        step(1, 0, 2'd1, 8'h55);
        rd_expect(2'd0, 8'hC0, "R5 write in result phase ignored");
        expect_results('{8'h80, 0}, "R5 results unchanged");
        rd_expect(2'd1, 8'h00, "R5 idle data read returns zero");
        rd_expect(2'd0, 8'h80, "R5 idle data read no effect");

        cur_req = "R3";
        send('{8'h03, 8'hAF, 8'h02}); idle();
        rd_expect(2'd0, 8'h80, "R3 specify returns to idle");

        cur_req = "R10";
        step(1, 0, 2'd3, 8'h9D); idle();
        chk("R10 drive select", drv_sel, 1);
        chk("R10 motor enables", motor_en, 9);
        chk("R10 dma enable", dma_en, 1);
        rd_expect(2'd2, 8'h00, "R11 no interrupt without arming");

        cur_req = "R11";
        step(1, 0, 2'd3, 8'h08);
        rd_expect(2'd2, 8'h00, "R11 armed, no interrupt");
        step(1, 0, 2'd3, 8'h0C);
        rd_expect(2'd2, 8'hC0, "R12 interrupt after drive 0 reset");
        chk("R11 irq pin after reset", irq, 1);
        step(1, 0, 2'd3, 8'h08);
        rd_expect(2'd2, 8'h00, "R11 arming clears interrupt");
        step(1, 0, 2'd3, 8'h0D);
        rd_expect(2'd2, 8'h00, "R11 drive 1 reset raises nothing");

        cur_req = "R13";
        send('{8'h0F, 8'h00, 8'h30}); idle();
        send('{8'h06, 8'h00, 8'h01});
        rd_expect(2'd0, 8'h80, "R13 partial command collecting");
        step(1, 0, 2'd3, 8'h08);
        step(1, 0, 2'd3, 8'h0C);
        rd_expect(2'd0, 8'h80, "R13 idle after abort");
        send('{8'h08}); idle();
        rd_expect(2'd0, 8'hC0, "R13 new command accepted");
        expect_results('{0, 8'h30}, "R13 status cleared, cylinder kept");

        idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule